// File: doc/BRIEF.md
# Two-Bank Priority Interrupt Controller

This block gathers 32 interrupt inputs and presents them to a processor through two independent request outputs: a normal request and a fast request. Every input first passes through a per-source polarity stage and then a per-source capture stage. The capture stage either follows the input level or holds a detected event until software acknowledges it. Both of these stages are shared by the two output banks. Each bank then applies its own enable mask and its own priority threshold. It picks the most urgent pending source and drives its request line while anything remains to be serviced.

Software reaches the block through a simple 32-bit register port with separate read and write strobes. Read data is combinational from the address. A read of a bank's acknowledge register has a side effect that takes hold at the clock edge. Each source carries a 4-bit priority in which 0 is the most urgent. A handler repeatedly reads the bank's current-source register until that bank's masked status reads zero.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset both request outputs are low, every enable bit is 0, every source priority reads 0, the polarity register reads 0xFFFFFFFF, the capture-mode register reads 0, and both thresholds read 0xF.
- R2: Bank 0 sits at byte address 0x000 and bank 1 at 0x100. Within a bank the offsets are: masked status 0x00, raw status 0x04, enable-set 0x08, enable-clear 0x0C, current source 0x20, acknowledge 0x28, threshold 0x2C. Polarity is at 0x200, capture mode at 0x204, and the priority of source n at 0x300 + 4*n.
- R3: A write to enable-set ORs the written ones into the bank's enable mask. A write to enable-clear clears the bits written as one. Writing 0xFFFFFFFF to enable-clear drops that bank's request on the next cycle. Both offsets read back the enable mask.
- R4: A polarity bit of 1 passes its input unchanged, and a bit of 0 inverts it. Raw status shows the result.
- R5: A source whose capture-mode bit is 0 is level-sensitive. Its raw status bit follows the polarity-adjusted input in the same cycle.
- R6: A source whose capture-mode bit is 1 becomes pending on the cycle after its adjusted input is seen true. It stays pending until an acknowledge read of a bank whose enable mask includes that source, provided the input is then inactive. An acknowledge of a bank that does not enable the source leaves it pending.
- R7: Masked status is raw status ANDed with the enable mask, further restricted to sources whose priority value is less than or equal to the threshold. The bank's request output is high exactly when masked status is nonzero.
- R8: The current-source register returns the masked-status source with the lowest priority value, breaking ties toward the lowest source number. It reads 0 when masked status is zero.
- R9: The two banks hold separate enable masks and thresholds. The normal request follows bank 0 and the fast request follows bank 1.
- R10: An acknowledge read returns the bank's masked status as it was before the clear.
- R11: Addresses outside the map read 0. Writes to status, current-source and acknowledge offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers acknowledge side effect) |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_in | input | 32 | Interrupt source inputs |
| irq_o | output | 1 | Normal request (bank 0) |
| fiq_o | output | 1 | Fast request (bank 1) |

## Verification
Selection is tried with three sources pending at once. Two of them share the best priority value, so the lowest-number tie-break is exposed. The third has a worse value and only wins once the other two drop. A threshold below the shared value shows that filtering removes sources before selection and silences the request. A one-cycle pulse on a held-capture source enabled only in the fast bank shows that the two banks are independent, that the normal bank's acknowledge does not clear it, and that the fast bank's acknowledge does. An inverted polarity bit with all inputs low shows that polarity acts before the status views of both banks.

// File: rtl/intc_pkg.sv
// Package: shared widths and register offsets of the two-bank interrupt
// controller. Assumes byte addressing with 32-bit word registers.
package intc_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int PRIO_W  = 4;

    // Offsets inside one bank window (low 8 address bits)
    localparam logic [7:0] OFS_STAT   = 8'h00;
    localparam logic [7:0] OFS_RAW    = 8'h04;
    localparam logic [7:0] OFS_ENSET  = 8'h08;
    localparam logic [7:0] OFS_ENCLR  = 8'h0C;
    localparam logic [7:0] OFS_CUR    = 8'h20;
    localparam logic [7:0] OFS_ACK    = 8'h28;
    localparam logic [7:0] OFS_THR    = 8'h2C;

    // Shared configuration registers
    localparam logic [ADDR_W-1:0] ADR_POL    = 12'h200;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 12'h204;
    localparam logic [4:0]        PRIO_PAGE  = 5'd6;   // addr[11:7] of 0x300..0x37C

    typedef enum logic [1:0] {
        REG_BANK0 = 2'd0,
        REG_BANK1 = 2'd1,
        REG_SHARE = 2'd2,
        REG_NONE  = 2'd3
    } region_e;
endpackage

// File: rtl/intc_capture.sv
// Module: per-source polarity and capture stage shared by both banks.
// Adjusted input = input XNOR polarity bit. Level sources expose the adjusted
// input directly; held sources set a latch that clears only on clr_mask.
// Assumes clr_mask is a one-cycle pulse vector from the acknowledge logic.
module intc_capture #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] hold_mode,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] cond,
    output logic [NUM_SRC-1:0] latch,
    output logic [NUM_SRC-1:0] pend
);
    // Polarity adjust: 1 passes through, 0 inverts
    always_comb cond = ~(src_in ^ pol);

    // Event latch: set on adjusted input, clear on acknowledge, forced off in level mode
    always_ff @(posedge clk) begin
        if (!rst_n) latch <= '0;
        else        latch <= ((latch & ~clr_mask) | (cond & hold_mode)) & hold_mode;
    end

    // Pending view: latch for held sources, adjusted input for level sources
    always_comb pend = (hold_mode & latch) | (~hold_mode & cond);
endmodule

// File: rtl/intc_arbiter.sv
// Module: picks the requesting source with the lowest priority value,
// ties going to the lowest index. Purely combinational. Reports index 0
// when nothing requests.
module intc_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 4,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [SRC_W-1:0]          win,
    output logic                      any
);
    // Linear scan keeping the strictly better candidate
    always_comb begin
        logic [PRIO_W-1:0] best_p;
        any    = 1'b0;
        best_p = '0;
        win    = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (req[n] && (!any || prio_flat[n*PRIO_W +: PRIO_W] < best_p)) begin
                any    = 1'b1;
                best_p = prio_flat[n*PRIO_W +: PRIO_W];
                win    = SRC_W'(n);
            end
        end
    end
endmodule

// File: rtl/intc_bank.sv
// Module: one output bank - enable mask, threshold, masked/raw views,
// winner selection and acknowledge strobe. Register access arrives already
// decoded to this bank; offs is the in-window byte offset.
module intc_bank
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [7:0]                offs,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_SRC-1:0]        enable,
    output logic [PRIO_W-1:0]         thresh,
    output logic [SRC_W-1:0]          cur,
    output logic                      ack,
    output logic                      req
);
    logic [NUM_SRC-1:0] accept;
    logic [NUM_SRC-1:0] masked;
    logic               any;

    // Enable mask: set-ones and clear-ones writes
    always_ff @(posedge clk) begin
        if (!rst_n)                          enable <= '0;
        else if (wr_en && offs == OFS_ENSET) enable <= enable | wdata[NUM_SRC-1:0];
        else if (wr_en && offs == OFS_ENCLR) enable <= enable & ~wdata[NUM_SRC-1:0];
    end

    // Threshold register, resets to accept all priorities
    always_ff @(posedge clk) begin
        if (!rst_n)                        thresh <= '1;
        else if (wr_en && offs == OFS_THR) thresh <= wdata[PRIO_W-1:0];
    end

    // Priority filter per source
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_accept
        assign accept[g] = prio_flat[g*PRIO_W +: PRIO_W] <= thresh;
    end

    // Masked view feeds request and arbiter
    always_comb masked = pend & enable & accept;

    intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .req       (masked),
        .prio_flat (prio_flat),
        .win       (cur),
        .any       (any)
    );

    // Request and acknowledge strobe
    always_comb begin
        req = any;
        ack = rd_en && offs == OFS_ACK;
    end

    // Bank read multiplexer
    always_comb begin
        unique case (offs)
            OFS_STAT, OFS_ACK:    rdata = DATA_W'(masked);
            OFS_RAW:              rdata = DATA_W'(pend);
            OFS_ENSET, OFS_ENCLR: rdata = DATA_W'(enable);
            OFS_CUR:              rdata = DATA_W'(cur);
            OFS_THR:              rdata = DATA_W'(thresh);
            default:              rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_dual_bank.sv
// Module: top of the two-bank priority interrupt controller. Decodes the
// register port, holds the shared polarity, capture-mode and priority
// registers, and instantiates the capture stage and two banks.
// Assumes NUM_SRC <= 32 so every per-source vector fits one data word.
module intc_dual_bank
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int NBANK  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [NUM_SRC-1:0]        pol;
    logic [NUM_SRC-1:0]        hold_mode;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]        cond, latch, pend, clr_mask;
    region_e                   region;
    logic                      prio_hit;
    logic [4:0]                prio_idx;

    logic [DATA_W-1:0]  bank_rdata [NBANK];
    logic [NUM_SRC-1:0] bank_en    [NBANK];
    logic [PRIO_W-1:0]  bank_thr   [NBANK];
    logic [SRC_W-1:0]   bank_cur   [NBANK];
    logic [NBANK-1:0]   bank_ack;
    logic [NBANK-1:0]   bank_req;

    // Address region decode
    always_comb begin
        prio_hit = bus_addr[11:7] == PRIO_PAGE && bus_addr[1:0] == 2'b00
                   && int'(bus_addr[6:2]) < NUM_SRC;
        prio_idx = bus_addr[6:2];
        unique case (bus_addr[11:8])
            4'h0:    region = REG_BANK0;
            4'h1:    region = REG_BANK1;
            4'h2,
            4'h3:    region = REG_SHARE;
            default: region = REG_NONE;
        endcase
    end

    // Polarity and capture-mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol       <= '1;
            hold_mode <= '0;
        end else if (bus_wr && bus_addr == ADR_POL) begin
            pol       <= bus_wdata[NUM_SRC-1:0];
        end else if (bus_wr && bus_addr == ADR_MODE) begin
            hold_mode <= bus_wdata[NUM_SRC-1:0];
        end
    end

    // Per-source priority registers
    always_ff @(posedge clk) begin
        if (!rst_n)                 prio_flat <= '0;
        else if (bus_wr && prio_hit) prio_flat[prio_idx*PRIO_W +: PRIO_W] <= bus_wdata[PRIO_W-1:0];
    end

    // Acknowledge clears sources enabled in the acknowledging bank
    always_comb begin
        clr_mask = '0;
        for (int b = 0; b < NBANK; b++)
            if (bank_ack[b]) clr_mask = clr_mask | bank_en[b];
    end

    intc_capture #(.NUM_SRC(NUM_SRC)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .pol       (pol),
        .hold_mode (hold_mode),
        .clr_mask  (clr_mask),
        .cond      (cond),
        .latch     (latch),
        .pend      (pend)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        intc_bank #(.NUM_SRC(NUM_SRC)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_wr && region == region_e'(b)),
            .rd_en     (bus_rd && region == region_e'(b)),
            .offs      (bus_addr[7:0]),
            .wdata     (bus_wdata),
            .pend      (pend),
            .prio_flat (prio_flat),
            .rdata     (bank_rdata[b]),
            .enable    (bank_en[b]),
            .thresh    (bank_thr[b]),
            .cur       (bank_cur[b]),
            .ack       (bank_ack[b]),
            .req       (bank_req[b])
        );
    end

    // Request outputs
    always_comb begin
        irq_o = bank_req[0];
        fiq_o = bank_req[1];
    end

    // Top-level read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (region)
            REG_BANK0: bus_rdata = bank_rdata[0];
            REG_BANK1: bus_rdata = bank_rdata[1];
            REG_SHARE: begin
                if (bus_addr == ADR_POL)       bus_rdata = DATA_W'(pol);
                else if (bus_addr == ADR_MODE) bus_rdata = DATA_W'(hold_mode);
                else if (prio_hit)             bus_rdata = DATA_W'(prio_flat[prio_idx*PRIO_W +: PRIO_W]);
            end
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_dual_bank_chk.sv
// Module: assertion checker for intc_dual_bank, attached by bind.
// Observes ports and the shared capture and bank state.
module intc_dual_bank_chk
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic                      irq_o,
    input logic                      fiq_o,
    input logic [NUM_SRC-1:0]        pend,
    input logic [NUM_SRC-1:0]        cond,
    input logic [NUM_SRC-1:0]        latch,
    input logic [NUM_SRC-1:0]        hold_mode,
    input logic [NUM_SRC-1:0]        en0,
    input logic [NUM_SRC-1:0]        en1,
    input logic [PRIO_W-1:0]         thr0,
    input logic [SRC_W-1:0]          cur0,
    input logic [SRC_W-1:0]          cur1,
    input logic                      ack0,
    input logic                      ack1,
    input logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
    // R3: clearing every enable of bank 0 drops the normal request
    p_clear_all_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h00C && bus_wdata == '1) |=> !irq_o);

    // R7: a normal request needs an enabled pending source
    p_req_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend & en0) != '0);

    // R7: a fast request needs an enabled pending source in bank 1
    p_fast_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (pend & en1) != '0);

    // R8: the winner is pending, enabled and within the threshold
    p_winner_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend[cur0] && en0[cur0] && prio_flat[cur0*PRIO_W +: PRIO_W] <= thr0));

    // R8: current source reads 0 while idle
    p_idle_cur_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o |-> cur0 == '0) and (!fiq_o |-> cur1 == '0));

    // R6: held events persist without acknowledge or mode change
    p_hold_persists_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack0 && !ack1 && !(bus_wr && bus_addr == ADR_MODE))
        |=> (($past(latch) & $past(hold_mode)) & ~latch) == '0);

    // R6: acknowledge with inactive inputs clears enabled held sources
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack0 && (cond & hold_mode) == '0) |=> (latch & $past(en0)) == '0);
endmodule

bind intc_dual_bank intc_dual_bank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .pend      (pend),
    .cond      (cond),
    .latch     (latch),
    .hold_mode (hold_mode),
    .en0       (bank_en[0]),
    .en1       (bank_en[1]),
    .thr0      (bank_thr[0]),
    .cur0      (bank_cur[0]),
    .cur1      (bank_cur[1]),
    .ack0      (bank_ack[0]),
    .ack1      (bank_ack[1]),
    .prio_flat (prio_flat)
);

// File: tb/tb_intc_dual_bank.sv
// Bench: directed scenarios for intc_dual_bank, one task per scenario.
module tb_intc_dual_bank;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic        irq_o, fiq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    intc_dual_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq_o}, 32'd0);
        check("R1 fiq", {31'b0, fiq_o}, 32'd0);
        rd(12'h02C, d); check("R1 thr0", d, 32'hF);
        rd(12'h12C, d); check("R1 thr1", d, 32'hF);
        rd(12'h200, d); check("R1 polarity", d, 32'hFFFF_FFFF);
        rd(12'h204, d); check("R1 mode", d, 32'h0);
        rd(12'h314, d); check("R1 prio5", d, 32'h0);
        rd(12'h008, d); check("R1 en0", d, 32'h0);
        rd(12'h10C, d); check("R1 en1", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(12'h008, 32'h0000_0009);
        wr(12'h00C, 32'h0000_0001);
        rd(12'h008, d); check("R3 enable set/clear", d, 32'h8);
        @(negedge clk); src_in[3] = 1'b1; #1;
        check("R5 irq follows level", {31'b0, irq_o}, 32'd1);
        rd(12'h004, d); check("R5 raw", d, 32'h8);
        rd(12'h000, d); check("R7 masked", d, 32'h8);
        rd(12'h020, d); check("R8 current", d, 32'd3);
        @(negedge clk); src_in[3] = 1'b0; #1;
        check("R5 level drop", {31'b0, irq_o}, 32'd0);
        wr(12'h00C, 32'hFFFF_FFFF);
    endtask

    task automatic t_polarity();
        logic [31:0] d;
        src_in = '0;
        wr(12'h200, ~32'h80);
        rd(12'h004, d); check("R4 inverted raw bank0", d, 32'h80);
        rd(12'h104, d); check("R4 inverted raw bank1", d, 32'h80);
        check("R7 no enable no irq", {31'b0, irq_o}, 32'd0);
        wr(12'h200, 32'hFFFF_FFFF);
        rd(12'h004, d); check("R4 restored", d, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        wr(12'h328, 32'd2);
        wr(12'h310, 32'd5);
        wr(12'h350, 32'd2);
        rd(12'h350, d); check("R2 prio20 readback", d, 32'd2);
        wr(12'h008, 32'h0010_0410);
        @(negedge clk); src_in = 32'h0010_0410;
        rd(12'h020, d); check("R8 tie low index", d, 32'd10);
        check("R9 fiq idle", {31'b0, fiq_o}, 32'd0);
        wr(12'h02C, 32'd1);
        rd(12'h000, d); check("R7 threshold filters", d, 32'h0);
        rd(12'h020, d); check("R8 filtered current", d, 32'd0);
        check("R7 irq off", {31'b0, irq_o}, 32'd0);
        wr(12'h02C, 32'd2);
        rd(12'h000, d); check("R7 threshold equal", d, 32'h0010_0400);
        wr(12'h02C, 32'hF);
        @(negedge clk); src_in[10] = 1'b0;
        rd(12'h020, d); check("R8 next tie", d, 32'd20);
        @(negedge clk); src_in[20] = 1'b0;
        rd(12'h020, d); check("R8 worse prio wins alone", d, 32'd4);
        wr(12'h00C, 32'hFFFF_FFFF);
        check("R3 clear all", {31'b0, irq_o}, 32'd0);
        src_in = '0;
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        wr(12'h204, 32'h1000);
        wr(12'h108, 32'h1000);
        @(negedge clk); src_in[12] = 1'b1;
        @(negedge clk); src_in[12] = 1'b0; #1;
        check("R6 fast held", {31'b0, fiq_o}, 32'd1);
        check("R9 normal unaffected", {31'b0, irq_o}, 32'd0);
        rd(12'h028, d); check("R10 ack bank0 data", d, 32'h0);
        check("R6 foreign ack keeps", {31'b0, fiq_o}, 32'd1);
        rd(12'h120, d); check("R8 fast current", d, 32'd12);
        rd(12'h128, d); check("R10 ack bank1 data", d, 32'h1000);
        check("R6 ack clears", {31'b0, fiq_o}, 32'd0);
        rd(12'h104, d); check("R6 raw cleared", d, 32'h0);
        wr(12'h204, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(12'h040, d); check("R11 unmapped", d, 32'h0);
        rd(12'h800, d); check("R11 high unmapped", d, 32'h0);
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h004, d); check("R11 raw write ignored", d, 32'h0);
        rd(12'h008, d); check("R11 enable untouched", d, 32'h0);
        rd(12'h02C, d); check("R11 thr untouched", d, 32'hF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_polarity();
        t_priority();
        t_sticky();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule